// File: doc/BRIEF.md
# Program Sequencer with Carry-Saving Return Stack

This block is the instruction sequencing unit of a small 4-bit controller. It owns the program counter that addresses the program ROM. Each cycle it takes one operation from the decoder and picks the next fetch address. The choices are the following word, a jump target, an interrupt vector, a table entry built from two nibble registers, or an address popped from a hardware return stack.

The program counter is 12 bits wide. Its top bit selects the upper or lower 2K page and is only changed by an explicit load. The low 11 bits count on their own. The return stack has four levels and is shared by subroutine calls and interrupt entries. Each level holds the return address and the carry flag that was current when it was pushed.

Two return operations exist. The interrupt return gives back both the address and the saved carry. The constant return gives back only the address and passes one byte of a ROM word to the table and accumulator registers. Decode, the ALU and the ROM are outside this block.

Top module: `prog_seq`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `romAddr` is 0x000, the stack is empty, and `cyValid` and `constValid` are 0.
- R2: With `opCode` 3'd0 (step), bits 10..0 of `romAddr` increase by one after the clock edge and wrap from 0x7FF to 0x000, while bit 11 keeps its value.
- R3: With `opCode` 3'd1 (jump), `romAddr` takes all 12 bits of `jumpTarget`, page bit included, after the clock edge.
- R4: With `opCode` 3'd2 (call) or 3'd3 (interrupt entry), a 13-bit entry is pushed: `carryIn` in bit 12, and in bits 11..0 the address that a step from the current `romAddr` would give. `romAddr` then takes `jumpTarget` (call) or `intVector` (interrupt).
- R5: With `opCode` 3'd4 (table jump), `romAddr` becomes {current `romAddr`[11:8], `tbrIn`, `accIn`}.
- R6: With `opCode` 3'd5 (interrupt return), the top entry is popped. `romAddr` takes its bits 11..0, and in the next cycle `cyValid` is 1 for exactly one cycle with `cyRestore` equal to its bit 12.
- R7: With `opCode` 3'd6 (constant return), the top entry is popped and `romAddr` takes its bits 11..0. `cyValid` stays 0. In the next cycle `constValid` is 1 for one cycle, with `tbrOut` = `romWord`[7:4] and `accOut` = `romWord`[3:0].
- R8: Calls and interrupt entries share one last-in first-out stack of four levels. Returns pop entries in reverse order of their pushes, whichever push or return kind is mixed.
- R9: A push while four entries are held drops the oldest entry. Later pops give back the four newest entries, newest first.
- R10: The stack is a shift register in which a pop copies each level up and keeps the bottom level. A pop with no entries held does not fault: it returns the value that this shift brings to the top, the depth stays at zero, and later pushes and pops behave normally.
- R11: With `opCode` 3'd7 (hold), `romAddr` and the stack keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 3 | Sequencing operation for this cycle |
| jumpTarget | input | 12 | Destination of jump and call |
| intVector | input | 12 | Destination of interrupt entry |
| tbrIn | input | 4 | Table branch register value |
| accIn | input | 4 | Accumulator value |
| carryIn | input | 1 | Current carry flag, saved on push |
| romWord | input | 16 | ROM word fetched for a constant return |
| romAddr | output | 12 | Program counter, the ROM fetch address |
| cyRestore | output | 1 | Carry flag popped by an interrupt return |
| cyValid | output | 1 | One-cycle strobe qualifying `cyRestore` |
| tbrOut | output | 4 | Table register load value from a constant return |
| accOut | output | 4 | Accumulator load value from a constant return |
| constValid | output | 1 | One-cycle strobe qualifying `tbrOut` and `accOut` |

## Verification
The bench uses the default parameters: a 12-bit counter, 4-bit nibbles, a four-level stack and a 16-bit ROM word. With these values, page wrap at 0x7FF and 0xFFF is reached by a single jump followed by one or two steps. A full stack and its overflow are reached in five pushes, so the random stream of about three thousand operations hits overflow and empty-stack pops many times. The page bit, table nibble placement and carry slot at bit 12 are all checked at their real positions.

// File: rtl/prog_seq_pkg.sv
`timescale 1ns/1ps
package prog_seq_pkg;

  typedef enum logic [2:0] {
    OP_STEP  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_IRQ   = 3'd3,
    OP_TABLE = 3'd4,
    OP_RETI  = 3'd5,
    OP_RETK  = 3'd6,
    OP_HOLD  = 3'd7
  } seqOp_e;

  typedef enum logic [2:0] {
    SRC_INC  = 3'd0,
    SRC_TGT  = 3'd1,
    SRC_VEC  = 3'd2,
    SRC_TBL  = 3'd3,
    SRC_STK  = 3'd4,
    SRC_KEEP = 3'd5
  } pcSrc_e;

  typedef struct packed {
    pcSrc_e pcSrc;
    logic   push;
    logic   pop;
    logic   cyLoad;
    logic   kLoad;
  } seqCtl_t;

endpackage

// File: rtl/prog_seq_stack.sv
`timescale 1ns/1ps
module prog_seq_stack #(
  parameter int DEPTH   = 4,
  parameter int ENTRY_W = 13,
  localparam int DW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               push,
  input  logic               pop,
  input  logic [ENTRY_W-1:0] pushData,
  output logic [ENTRY_W-1:0] topData,
  output logic [DW-1:0]      depth
);

  logic [ENTRY_W-1:0] level [DEPTH];

  // level 0 is the top; a push shifts down and loses the bottom,
  // a pop shifts up and the bottom keeps its own value
  for (genvar i = 0; i < DEPTH; i++) begin : g_level
    if (i == 0 && DEPTH > 1) begin : g_top
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     level[i] <= '0;
        else if (push) level[i] <= pushData;
        else if (pop)  level[i] <= level[i+1];
      end
    end else if (i == 0) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     level[i] <= '0;
        else if (push) level[i] <= pushData;
      end
    end else if (i == DEPTH - 1) begin : g_bottom
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     level[i] <= '0;
        else if (push) level[i] <= level[i-1];
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     level[i] <= '0;
        else if (push) level[i] <= level[i-1];
        else if (pop)  level[i] <= level[i+1];
      end
    end
  end

  assign topData = level[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
    end else if (push && !pop) begin
      if (depth != DW'(DEPTH)) depth <= depth + 1'b1;
    end else if (pop && !push) begin
      if (depth != '0) depth <= depth - 1'b1;
    end
  end

endmodule

// File: rtl/prog_seq_ctrl.sv
`timescale 1ns/1ps
module prog_seq_ctrl
  import prog_seq_pkg::*;
(
  input  logic [2:0] opCode,
  output seqCtl_t    ctl
);

  seqOp_e op;
  assign op = seqOp_e'(opCode);

  always_comb begin
    ctl = '{pcSrc: SRC_INC, push: 1'b0, pop: 1'b0, cyLoad: 1'b0, kLoad: 1'b0};
    unique case (op)
      OP_STEP:  ctl.pcSrc = SRC_INC;
      OP_JUMP:  ctl.pcSrc = SRC_TGT;
      OP_CALL: begin
        ctl.pcSrc = SRC_TGT;
        ctl.push  = 1'b1;
      end
      OP_IRQ: begin
        ctl.pcSrc = SRC_VEC;
        ctl.push  = 1'b1;
      end
      OP_TABLE: ctl.pcSrc = SRC_TBL;
      OP_RETI: begin
        ctl.pcSrc  = SRC_STK;
        ctl.pop    = 1'b1;
        ctl.cyLoad = 1'b1;
      end
      OP_RETK: begin
        ctl.pcSrc = SRC_STK;
        ctl.pop   = 1'b1;
        ctl.kLoad = 1'b1;
      end
      OP_HOLD:  ctl.pcSrc = SRC_KEEP;
      default:  ctl.pcSrc = SRC_KEEP;
    endcase
  end

endmodule

// File: rtl/prog_seq_dp.sv
`timescale 1ns/1ps
module prog_seq_dp
  import prog_seq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int NIB_W = 4,
  parameter int DEPTH = 4,
  parameter int ROM_W = 16,
  localparam int LOW_W   = PC_W - 1,
  localparam int ENTRY_W = PC_W + 1,
  localparam int DW      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [PC_W-1:0]  jumpTarget,
  input  logic [PC_W-1:0]  intVector,
  input  logic [NIB_W-1:0] tbrIn,
  input  logic [NIB_W-1:0] accIn,
  input  logic             carryIn,
  input  logic [ROM_W-1:0] romWord,
  output logic [PC_W-1:0]  pc,
  output logic             cyRestore,
  output logic             cyValid,
  output logic [NIB_W-1:0] tbrOut,
  output logic [NIB_W-1:0] accOut,
  output logic             constValid,
  output logic [DW-1:0]    stackDepth
);

  localparam logic [LOW_W-1:0] ONE_LOW = LOW_W'(1);

  logic [PC_W-1:0]    stepPc;
  logic [PC_W-1:0]    tablePc;
  logic [PC_W-1:0]    nextPc;
  logic [ENTRY_W-1:0] pushData;
  logic [ENTRY_W-1:0] topData;
  logic               unusedRomHi;

  // page bit held, low counter rolls over inside its page
  assign stepPc   = {pc[PC_W-1], pc[LOW_W-1:0] + ONE_LOW};
  assign tablePc  = {pc[PC_W-1:2*NIB_W], tbrIn, accIn};
  assign pushData = {carryIn, stepPc};
  assign unusedRomHi = ^romWord[ROM_W-1:2*NIB_W];

  always_comb begin
    unique case (ctl.pcSrc)
      SRC_INC:  nextPc = stepPc;
      SRC_TGT:  nextPc = jumpTarget;
      SRC_VEC:  nextPc = intVector;
      SRC_TBL:  nextPc = tablePc;
      SRC_STK:  nextPc = topData[PC_W-1:0];
      SRC_KEEP: nextPc = pc;
      default:  nextPc = pc;
    endcase
  end

  prog_seq_stack #(
    .DEPTH  (DEPTH),
    .ENTRY_W(ENTRY_W)
  ) stack_i (
    .clk     (clk),
    .rstN    (rstN),
    .push    (ctl.push),
    .pop     (ctl.pop),
    .pushData(pushData),
    .topData (topData),
    .depth   (stackDepth)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc         <= '0;
      cyRestore  <= 1'b0;
      cyValid    <= 1'b0;
      tbrOut     <= '0;
      accOut     <= '0;
      constValid <= 1'b0;
    end else begin
      pc         <= nextPc;
      cyValid    <= ctl.cyLoad;
      constValid <= ctl.kLoad;
      if (ctl.cyLoad) cyRestore <= topData[ENTRY_W-1];
      if (ctl.kLoad) begin
        tbrOut <= romWord[2*NIB_W-1:NIB_W];
        accOut <= romWord[NIB_W-1:0];
      end
    end
  end

endmodule

// File: rtl/prog_seq.sv
`timescale 1ns/1ps
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int NIB_W = 4,
  parameter int DEPTH = 4,
  parameter int ROM_W = 16,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       opCode,
  input  logic [PC_W-1:0]  jumpTarget,
  input  logic [PC_W-1:0]  intVector,
  input  logic [NIB_W-1:0] tbrIn,
  input  logic [NIB_W-1:0] accIn,
  input  logic             carryIn,
  input  logic [ROM_W-1:0] romWord,
  output logic [PC_W-1:0]  romAddr,
  output logic             cyRestore,
  output logic             cyValid,
  output logic [NIB_W-1:0] tbrOut,
  output logic [NIB_W-1:0] accOut,
  output logic             constValid
);

  seqCtl_t       ctl;
  logic [DW-1:0] stackDepth;

  prog_seq_ctrl ctrl_i (
    .opCode(opCode),
    .ctl   (ctl)
  );

  prog_seq_dp #(
    .PC_W (PC_W),
    .NIB_W(NIB_W),
    .DEPTH(DEPTH),
    .ROM_W(ROM_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .jumpTarget(jumpTarget),
    .intVector (intVector),
    .tbrIn     (tbrIn),
    .accIn     (accIn),
    .carryIn   (carryIn),
    .romWord   (romWord),
    .pc        (romAddr),
    .cyRestore (cyRestore),
    .cyValid   (cyValid),
    .tbrOut    (tbrOut),
    .accOut    (accOut),
    .constValid(constValid),
    .stackDepth(stackDepth)
  );

endmodule

// File: rtl/prog_seq_chk.sv
`timescale 1ns/1ps
module prog_seq_chk #(
  parameter int PC_W  = 12,
  parameter int NIB_W = 4,
  parameter int DEPTH = 4,
  parameter int ROM_W = 16,
  localparam int LOW_W = PC_W - 1,
  localparam int DW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       opCode,
  input logic [PC_W-1:0]  jumpTarget,
  input logic [PC_W-1:0]  intVector,
  input logic [NIB_W-1:0] tbrIn,
  input logic [NIB_W-1:0] accIn,
  input logic             carryIn,
  input logic [ROM_W-1:0] romWord,
  input logic [PC_W-1:0]  romAddr,
  input logic             cyRestore,
  input logic             cyValid,
  input logic [NIB_W-1:0] tbrOut,
  input logic [NIB_W-1:0] accOut,
  input logic             constValid,
  input logic [DW-1:0]    stackDepth
);

  logic unusedHi;
  assign unusedHi = ^romWord[ROM_W-1:2*NIB_W];

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (romAddr == '0 && stackDepth == '0 && !cyValid && !constValid));

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd0 |=> (romAddr[PC_W-1] == $past(romAddr[PC_W-1]) &&
                        romAddr[LOW_W-1:0] == LOW_W'($past(romAddr[LOW_W-1:0]) + 1)));

  a_r3_jump: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd1 |=> romAddr == $past(jumpTarget));

  a_r4_call_target: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd2 |=> romAddr == $past(jumpTarget));

  a_r4_irq_vector: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd3 |=> romAddr == $past(intVector));

  a_r5_table: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd4 |=> romAddr == {$past(romAddr[PC_W-1:2*NIB_W]), $past(tbrIn), $past(accIn)});

  a_r6_carry_strobe: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd5 |=> (cyValid && !constValid));

  a_r6_no_stray_carry: assert property (@(posedge clk) disable iff (!rstN)
    opCode != 3'd5 |=> !cyValid);

  a_r7_const_load: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd6 |=> (constValid && !cyValid &&
                        tbrOut == $past(romWord[2*NIB_W-1:NIB_W]) &&
                        accOut == $past(romWord[NIB_W-1:0])));

  // R8: a call followed at once by an interrupt return comes back to the step address with the saved carry
  a_r8_call_return: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 3'd2) ##1 (opCode == 3'd5) |=>
      (romAddr[PC_W-1] == $past(romAddr[PC_W-1], 2) &&
       romAddr[LOW_W-1:0] == LOW_W'($past(romAddr[LOW_W-1:0], 2) + 1) &&
       cyRestore == $past(carryIn, 2)));

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= DW'(DEPTH));

  a_r9_full_push: assert property (@(posedge clk) disable iff (!rstN)
    (stackDepth == DW'(DEPTH) && (opCode == 3'd2 || opCode == 3'd3)) |=> stackDepth == DW'(DEPTH));

  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (stackDepth == '0 && (opCode == 3'd5 || opCode == 3'd6)) |=> stackDepth == '0);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    opCode == 3'd7 |=> ($stable(romAddr) && $stable(stackDepth)));

endmodule

bind prog_seq prog_seq_chk #(
  .PC_W (PC_W),
  .NIB_W(NIB_W),
  .DEPTH(DEPTH),
  .ROM_W(ROM_W)
) chk_i (.*);

// File: tb/prog_seq_tb_top.sv
`timescale 1ns/1ps
module prog_seq_tb_top;

  localparam logic [2:0] K_STEP = 3'd0, K_JUMP = 3'd1, K_CALL = 3'd2, K_IRQ = 3'd3,
                         K_TBL = 3'd4, K_RETI = 3'd5, K_RETK = 3'd6, K_HOLD = 3'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = K_HOLD;
  logic [11:0] jumpTarget = '0;
  logic [11:0] intVector = '0;
  logic [3:0]  tbrIn = '0;
  logic [3:0]  accIn = '0;
  logic        carryIn = 1'b0;
  logic [15:0] romWord = '0;
  logic [11:0] romAddr;
  logic        cyRestore, cyValid, constValid;
  logic [3:0]  tbrOut, accOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  logic [11:0] mPc;
  logic [12:0] mStk [4];
  int          mDepth;

  always #2.5 clk = ~clk;

  prog_seq dut_i (
    .clk(clk), .rstN(rstN), .opCode(opCode), .jumpTarget(jumpTarget),
    .intVector(intVector), .tbrIn(tbrIn), .accIn(accIn), .carryIn(carryIn),
    .romWord(romWord), .romAddr(romAddr), .cyRestore(cyRestore), .cyValid(cyValid),
    .tbrOut(tbrOut), .accOut(accOut), .constValid(constValid)
  );

  function automatic logic [11:0] stepOf(logic [11:0] p);
    logic [10:0] low;
    low = p[10:0] + 11'd1;
    return {p[11], low};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mPush(logic [12:0] e);
    for (int i = 3; i > 0; i--) mStk[i] = mStk[i-1];
    mStk[0] = e;
    if (mDepth < 4) mDepth++;
  endtask

  task automatic mPop(output logic [12:0] e);
    e = mStk[0];
    for (int i = 0; i < 3; i++) mStk[i] = mStk[i+1];
    if (mDepth > 0) mDepth--;
  endtask

  // apply one operation, advance the model, compare after the edge
  task automatic doOp(string req, logic [2:0] op, logic [11:0] jt, logic [11:0] iv,
                      logic [3:0] tb, logic [3:0] ac, logic cy, logic [15:0] rw);
    logic [12:0] e;
    logic        eCyV, eCy, eKV;
    @(negedge clk);
    opCode = op; jumpTarget = jt; intVector = iv; tbrIn = tb; accIn = ac;
    carryIn = cy; romWord = rw;
    eCyV = 1'b0; eCy = 1'b0; eKV = 1'b0;
    case (op)
      K_STEP: mPc = stepOf(mPc);
      K_JUMP: mPc = jt;
      K_CALL: begin mPush({cy, stepOf(mPc)}); mPc = jt; end
      K_IRQ:  begin mPush({cy, stepOf(mPc)}); mPc = iv; end
      K_TBL:  mPc = {mPc[11:8], tb, ac};
      K_RETI: begin mPop(e); mPc = e[11:0]; eCyV = 1'b1; eCy = e[12]; end
      K_RETK: begin mPop(e); mPc = e[11:0]; eKV = 1'b1; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    check(req, 16'(romAddr), 16'(mPc));
    check(req, 16'(cyValid), 16'(eCyV));
    check(req, 16'(constValid), 16'(eKV));
    if (eCyV) check(req, 16'(cyRestore), 16'(eCy));
    if (eKV) check(req, {8'h00, tbrOut, accOut}, {8'h00, rw[7:0]});
  endtask

  task automatic quick(string req, logic [2:0] op, logic [11:0] jt, logic cy);
    doOp(req, op, jt, 12'h3C0, 4'h0, 4'h0, cy, 16'h0000);
  endtask

  initial begin
    mPc = '0; mDepth = 0;
    for (int i = 0; i < 4; i++) mStk[i] = '0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", 16'(romAddr), 16'h0);
    check("R1", 16'(cyValid), 16'h0);
    check("R1", 16'(constValid), 16'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1", 16'(romAddr), 16'h0);

    // R2 wrap within both pages
    quick("R3", K_JUMP, 12'h7FE, 1'b0);
    quick("R2", K_STEP, 12'h000, 1'b0);
    quick("R2", K_STEP, 12'h000, 1'b0);
    check("R2", 16'(romAddr), 16'h000);
    quick("R3", K_JUMP, 12'hFFF, 1'b0);
    quick("R2", K_STEP, 12'h000, 1'b0);
    check("R2", 16'(romAddr), 16'h800);

    // R5 table jump keeps upper nibble
    quick("R3", K_JUMP, 12'h9A7, 1'b0);
    doOp("R5", K_TBL, 12'h000, 12'h000, 4'hC, 4'h3, 1'b0, 16'h0000);
    check("R5", 16'(romAddr), 16'h9C3);

    // R11 hold
    quick("R11", K_HOLD, 12'h123, 1'b1);
    quick("R11", K_HOLD, 12'h456, 1'b0);

    // R8 mixed pushes and both return kinds
    quick("R4", K_CALL, 12'h100, 1'b1);
    doOp("R4", K_IRQ, 12'h000, 12'h004, 4'h0, 4'h0, 1'b0, 16'h0000);
    quick("R4", K_CALL, 12'hA20, 1'b1);
    doOp("R7", K_RETK, 12'h000, 12'h000, 4'h0, 4'h0, 1'b0, 16'hBE5A);
    quick("R8", K_RETI, 12'h000, 1'b1);
    check("R8", 16'(cyRestore), 16'h0);
    quick("R6", K_RETI, 12'h000, 1'b0);
    check("R6", 16'(cyRestore), 16'h1);

    // R9 overflow: five pushes, five pops
    for (int k = 0; k < 5; k++) quick("R9", K_CALL, 12'(12'h200 + 12'(k * 16)), 1'(k));
    for (int k = 0; k < 5; k++) quick("R9", K_RETI, 12'h000, 1'b0);

    // R10 extra pops on empty, then normal use
    quick("R10", K_RETI, 12'h000, 1'b0);
    doOp("R10", K_RETK, 12'h000, 12'h000, 4'h0, 4'h0, 1'b0, 16'h0071);
    quick("R10", K_CALL, 12'h555, 1'b1);
    quick("R10", K_CALL, 12'h666, 1'b0);
    quick("R10", K_RETI, 12'h000, 1'b0);
    quick("R10", K_RETI, 12'h000, 1'b0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op;
      string req;
      op = 3'($urandom % 8);
      case (op)
        K_STEP: req = "R2";
        K_JUMP: req = "R3";
        K_CALL, K_IRQ: req = "R4";
        K_TBL: req = "R5";
        K_RETI: req = "R6";
        K_RETK: req = "R7";
        default: req = "R11";
      endcase
      doOp(req, op, 12'($urandom), 12'($urandom), 4'($urandom), 4'($urandom),
           1'($urandom), 16'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule